// File: doc/BRIEF.md
# Channel-Steered Serial Configuration Register File

This block holds the configuration registers of a two-channel waveform generator and loads them over a serial control port. Each channel keeps a private copy of the per-channel register at a shared address. The one-byte select register at address 0x00 decides which of those copies a write reaches. It also sets the bit order and the number of data lanes used by every later transfer.

Writes to the function register and the per-channel register land in staging buffers. The values the generator uses change only on a rising edge of `io_update`. A write to the select register skips the staging and applies as soon as its byte completes. Reads return the active values. A transfer that loses chip select before it ends leaves nothing behind.

Top module: `srf_serial_regfile`

## Requirements
- R1: After reset the select register holds 0xC0 (both channel enables set, lane mode 00, MSB-first), `sel_err` is 0, and the function word and both channel words are 0.
- R2: A transfer starts with an instruction byte: bit 7 is the read flag (1 = read) and bits 4:0 are the address. It is followed by 1 data byte for address 0x00, 3 for 0x01, 4 for the per-channel address 0x04, and 1 for any other address. Writes to other addresses change nothing, and reads from them return 0.
- R3: With select bit 0 clear, bits go MSB-first, and multi-byte values go most significant byte first. With it set, both orders are reversed. Within one sck group, a higher lane index carries the more significant bit.
- R4: Select bits 2:1 set the lanes. For 00 and 01 one bit moves per sck rise on `sdi[0]`. For 10 two bits move on `sdi[1:0]`, and for 11 four bits move on `sdi[3:0]`. Read data comes out on `rdat[0]` in mode 00, on `rdat[2]` in mode 01, on `rdat[1:0]` in mode 10 and on `rdat[3:0]` in mode 11.
- R5: A select write with bit 3 set raises `sel_err`, and that bit reads back as 0. `sel_err` stays set until a select write with bit 3 clear.
- R6: A select write updates `ch_en`, `lane_mode` and `lsb_first` when its data byte completes, with no `io_update` needed.
- R7: Function and channel writes do not change the active outputs. On a rising edge of `io_update`, every staged value is copied to the outputs in the clock cycle that sees the edge.
- R8: With channel enables (select bits 7:6) at 01 a channel write reaches only channel 0. At 10 it reaches only channel 1, and at 11 both channels get the same value.
- R9: A read of the channel address returns channel 1 when the enables are 10, and channel 0 when they are 01 or 11. It returns 0 when they are 00.
- R10: Raising `csb` in the middle of a transfer abandons it. No staged value changes, and the next transfer starts with a new instruction byte.
- R11: Holding `io_update` high copies only once. Writes made while it stays high reach the outputs only on its next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csb | input | 1 | Active-low chip select framing transfers |
| sck | input | 1 | Serial clock, sampled on clk; data taken on its rising edge |
| sdi | input | 4 | Serial data lanes in |
| io_update | input | 1 | Rising edge copies staged values to active |
| rdat | output | 4 | Read data lanes out, zero outside read data |
| lsb_first | output | 1 | Current bit order |
| lane_mode | output | 2 | Current lane mode |
| ch_en | output | 2 | Current channel enables |
| sel_err | output | 1 | Last select write had bit 3 set |
| fr1_word | output | 24 | Active function register |
| ch0_word | output | 32 | Active channel 0 register |
| ch1_word | output | 32 | Active channel 1 register |

## Verification
A staging or steering fault shows up at the ports as a channel word that differs from the model on the cycle after an `io_update` edge. It can also show as a readback that returns the wrong copy. A slip in lane or bit-order handling corrupts the instruction byte itself. The very next transfer then lands at the wrong address or returns a scrambled read, so such faults show up within one transfer after a mode change. A bad abort path shows up as a changed word after the following update.

// File: rtl/srf_pkg.sv
package srf_pkg;
  typedef enum logic [1:0] {PH_INSTR = 2'd0, PH_WRITE = 2'd1, PH_READ = 2'd2} phase_t;
  localparam logic [4:0] ADDR_SEL = 5'h00;
  localparam logic [4:0] ADDR_FR1 = 5'h01;
  localparam logic [7:0] SEL_RST  = 8'hC0;
endpackage

// File: rtl/srf_lane_shift.sv
module srf_lane_shift #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clr_rx,
  input  logic             lsb_first,
  input  logic [2:0]       width_k,
  input  logic [3:0]       sdi,
  input  logic             load_tx,
  input  logic [ACC_W-1:0] tx_val,
  output logic [ACC_W-1:0] rx_nx,
  output logic [3:0]       tx_grp
);
  logic [ACC_W-1:0] acc_q, acc_d, tx_q, tx_d, gext;
  logic [3:0]       lane_mask;

  always_comb begin
    case (width_k)
      3'd4:    lane_mask = 4'hF;
      3'd2:    lane_mask = 4'h3;
      default: lane_mask = 4'h1;
    endcase
    gext = {{(ACC_W-4){1'b0}}, sdi & lane_mask};
    rx_nx = acc_q;
    if (step) begin
      if (lsb_first) rx_nx = (acc_q >> width_k) | (gext << (ACC_W - width_k));
      else           rx_nx = (acc_q << width_k) | gext;
    end
    acc_d = clr_rx ? '0 : rx_nx;
    tx_d = tx_q;
    if (load_tx)   tx_d = tx_val;
    else if (step) tx_d = lsb_first ? (tx_q >> width_k) : (tx_q << width_k);
    if (lsb_first) tx_grp = tx_q[3:0] & lane_mask;
    else           tx_grp = tx_q[ACC_W-1 -: 4] >> (4 - width_k);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      tx_q  <= '0;
    end else begin
      if (step || clr_rx)   acc_q <= acc_d;
      if (step || load_tx)  tx_q  <= tx_d;
    end
  end
endmodule

// File: rtl/srf_reg_bank.sv
module srf_reg_bank #(
  parameter int         FR1_BYTES = 3,
  parameter int         CHW_BYTES = 4,
  parameter logic [4:0] CHW_ADDR  = 5'h04,
  parameter int         ACC_W     = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [4:0]               wr_addr,
  input  logic [ACC_W-1:0]         wr_data,
  input  logic [1:0]               ch_en,
  input  logic                     upd_rise,
  input  logic [4:0]               rd_addr,
  output logic [ACC_W-1:0]         rd_val,
  output logic [8*FR1_BYTES-1:0]   fr1_word,
  output logic [2*8*CHW_BYTES-1:0] ch_words
);
  import srf_pkg::*;
  localparam int FW = 8*FR1_BYTES;
  localparam int CW = 8*CHW_BYTES;
  localparam int NCH = 2;

  logic          wr_fr1, wr_ch;
  logic [FW-1:0] frs_q, fra_q;

  assign wr_fr1 = wr_en && (wr_addr == ADDR_FR1);
  assign wr_ch  = wr_en && (wr_addr == CHW_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frs_q <= '0;
      fra_q <= '0;
    end else begin
      if (wr_fr1)   frs_q <= wr_data[FW-1:0];
      if (upd_rise) fra_q <= frs_q;
    end
  end
  assign fr1_word = fra_q;

  for (genvar g = 0; g < NCH; g++) begin : gen_ch
    logic [CW-1:0] stg_q, act_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q <= '0;
        act_q <= '0;
      end else begin
        if (wr_ch && ch_en[g]) stg_q <= wr_data[CW-1:0];
        if (upd_rise)          act_q <= stg_q;
      end
    end
    assign ch_words[g*CW +: CW] = act_q;

    AST_CH_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ch && !ch_en[g]) |=> $stable(stg_q)); // R8
  end

  always_comb begin
    rd_val = '0;
    if (rd_addr == ADDR_FR1) rd_val[FW-1:0] = fra_q;
    else if (rd_addr == CHW_ADDR) begin
      if (ch_en == 2'b10)      rd_val[CW-1:0] = gen_ch[1].act_q;
      else if (ch_en != 2'b00) rd_val[CW-1:0] = gen_ch[0].act_q;
    end
  end

  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_rise |=> $stable(fra_q)); // R7
  AST_CH_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ch && ch_en == 2'b11) |=> (gen_ch[0].stg_q == gen_ch[1].stg_q)); // R8
endmodule

// File: rtl/srf_serial_regfile.sv
module srf_serial_regfile #(
  parameter int         FR1_BYTES = 3,
  parameter int         CHW_BYTES = 4,
  parameter logic [4:0] CHW_ADDR  = 5'h04
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   csb,
  input  logic                   sck,
  input  logic [3:0]             sdi,
  input  logic                   io_update,
  output logic [3:0]             rdat,
  output logic                   lsb_first,
  output logic [1:0]             lane_mode,
  output logic [1:0]             ch_en,
  output logic                   sel_err,
  output logic [8*FR1_BYTES-1:0] fr1_word,
  output logic [8*CHW_BYTES-1:0] ch0_word,
  output logic [8*CHW_BYTES-1:0] ch1_word
);
  import srf_pkg::*;
  localparam int MAXB  = (FR1_BYTES > CHW_BYTES) ? FR1_BYTES : CHW_BYTES;
  localparam int ACC_W = 8*MAXB;
  localparam int BW    = $clog2(ACC_W+1);
  localparam int CWB   = 8*CHW_BYTES;

  phase_t           phase_q, phase_d;
  logic [BW-1:0]    bcnt_q, bcnt_d, kw, bsum, tgt;
  logic [4:0]       addr_q, addr_d, ib_addr;
  logic [7:0]       sel_q, sel_d;
  logic             err_q, err_d, sck_q, upd_q;
  logic             rise, upd_rise, ib_rd, instr_done, data_done, commit;
  logic             clr_rx, load_tx;
  logic [ACC_W-1:0] rx_nx, wval, bank_rd, rdv, tx_val;
  logic [3:0]       tx_grp;
  logic [2*CWB-1:0] ch_words;

  function automatic logic [BW-1:0] bits_of(input logic [4:0] a);
    if (a == ADDR_FR1)      return BW'(8*FR1_BYTES);
    else if (a == CHW_ADDR) return BW'(8*CHW_BYTES);
    else                    return BW'(8);
  endfunction

  assign rise     = sck && !sck_q && !csb;
  assign upd_rise = io_update && !upd_q;

  always_comb begin
    case (sel_q[2:1])
      2'b10:   kw = BW'(2);
      2'b11:   kw = BW'(4);
      default: kw = BW'(1);
    endcase
    bsum       = bcnt_q + kw;
    tgt        = bits_of(addr_q);
    ib_rd      = sel_q[0] ? rx_nx[ACC_W-1] : rx_nx[7];
    ib_addr    = sel_q[0] ? rx_nx[ACC_W-4 -: 5] : rx_nx[4:0];
    wval       = sel_q[0] ? (rx_nx >> (ACC_W - tgt)) : rx_nx;
    instr_done = rise && (phase_q == PH_INSTR) && (bsum == BW'(8));
    data_done  = rise && (phase_q != PH_INSTR) && (bsum == tgt);
    commit     = data_done && (phase_q == PH_WRITE);
    clr_rx     = csb || instr_done || data_done;
    load_tx    = instr_done && ib_rd;
    rdv        = (ib_addr == ADDR_SEL) ? {{(ACC_W-8){1'b0}}, sel_q} : bank_rd;
    tx_val     = sel_q[0] ? rdv : (rdv << (ACC_W - bits_of(ib_addr)));
  end

  always_comb begin
    phase_d = phase_q;
    bcnt_d  = bcnt_q;
    addr_d  = addr_q;
    sel_d   = sel_q;
    err_d   = err_q;
    if (csb) begin
      phase_d = PH_INSTR;
      bcnt_d  = '0;
    end else if (rise) begin
      bcnt_d = bsum;
      if (instr_done) begin
        bcnt_d  = '0;
        addr_d  = ib_addr;
        phase_d = ib_rd ? PH_READ : PH_WRITE;
      end else if (data_done) begin
        bcnt_d  = '0;
        phase_d = PH_INSTR;
        if (commit && addr_q == ADDR_SEL) begin
          sel_d = {wval[7:4], 1'b0, wval[2:0]};
          err_d = wval[3];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_INSTR;
      bcnt_q  <= '0;
      addr_q  <= '0;
      sel_q   <= SEL_RST;
      err_q   <= 1'b0;
      sck_q   <= 1'b0;
      upd_q   <= 1'b0;
    end else begin
      sck_q <= sck;
      upd_q <= io_update;
      if (csb || rise) begin
        phase_q <= phase_d;
        bcnt_q  <= bcnt_d;
        addr_q  <= addr_d;
        sel_q   <= sel_d;
        err_q   <= err_d;
      end
    end
  end

  srf_lane_shift #(.ACC_W(ACC_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .step(rise), .clr_rx(clr_rx),
    .lsb_first(sel_q[0]), .width_k(kw[2:0]), .sdi(sdi),
    .load_tx(load_tx), .tx_val(tx_val), .rx_nx(rx_nx), .tx_grp(tx_grp)
  );

  srf_reg_bank #(.FR1_BYTES(FR1_BYTES), .CHW_BYTES(CHW_BYTES),
                 .CHW_ADDR(CHW_ADDR), .ACC_W(ACC_W)) bank_i (
    .clk(clk), .rst_n(rst_n), .wr_en(commit && addr_q != ADDR_SEL),
    .wr_addr(addr_q), .wr_data(wval), .ch_en(sel_q[7:6]),
    .upd_rise(upd_rise), .rd_addr(ib_addr), .rd_val(bank_rd),
    .fr1_word(fr1_word), .ch_words(ch_words)
  );

  always_comb begin
    rdat = '0;
    if (phase_q == PH_READ)
      rdat = (sel_q[2:1] == 2'b01) ? {1'b0, tx_grp[0], 2'b00} : tx_grp;
  end

  assign lsb_first = sel_q[0];
  assign lane_mode = sel_q[2:1];
  assign ch_en     = sel_q[7:6];
  assign sel_err   = err_q;
  assign ch0_word  = ch_words[CWB-1:0];
  assign ch1_word  = ch_words[2*CWB-1:CWB];

  AST_ABORT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    csb |=> (phase_q == PH_INSTR && bcnt_q == '0)); // R10
  AST_SEL_NEEDS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(sel_q)); // R6
endmodule

// File: tb/srf_serial_regfile_tb.sv
module srf_serial_regfile_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, csb = 1'b1, sck = 1'b0, io_update = 1'b0;
  logic [3:0] sdi = '0, rdat;
  logic lsb_first, sel_err;
  logic [1:0] lane_mode, ch_en;
  logic [23:0] fr1_word;
  logic [31:0] ch0_word, ch1_word;

  int n_chk = 0, n_err = 0;
  logic m_lsb = 0, m_err = 0;
  logic [1:0] m_mode = 0, m_en = 2'b11, m_spare = 0;
  logic [23:0] m_fs = 0, m_fa = 0;
  logic [31:0] m_c0s = 0, m_c0a = 0, m_c1s = 0, m_c1a = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  srf_serial_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .csb(csb), .sck(sck), .sdi(sdi),
    .io_update(io_update), .rdat(rdat), .lsb_first(lsb_first),
    .lane_mode(lane_mode), .ch_en(ch_en), .sel_err(sel_err),
    .fr1_word(fr1_word), .ch0_word(ch0_word), .ch1_word(ch1_word)
  );

  function automatic int kw();
    return (m_mode == 2'b11) ? 4 : (m_mode == 2'b10) ? 2 : 1;
  endfunction
  function automatic int nbytes(input logic [4:0] a);
    return (a == 5'h01) ? 3 : (a == 5'h04) ? 4 : 1;
  endfunction
  function automatic logic [31:0] exp_read(input logic [4:0] a);
    if (a == 5'h00) return {24'h0, m_en, m_spare, 1'b0, m_mode, m_lsb};
    if (a == 5'h01) return {8'h0, m_fa};
    if (a == 5'h04) return (m_en == 2'b10) ? m_c1a : (m_en == 2'b00) ? 32'h0 : m_c0a;
    return 32'h0;
  endfunction

  task automatic tick(); @(negedge clk); endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_ports(input string req);
    check({req, " sel"}, {26'h0, ch_en, sel_err, lane_mode, lsb_first},
          {26'h0, m_en, m_err, m_mode, m_lsb});
    check({req, " fr1"}, {8'h0, fr1_word}, {8'h0, m_fa});
    check({req, " ch0"}, ch0_word, m_c0a);
    check({req, " ch1"}, ch1_word, m_c1a);
  endtask

  task automatic pulse(input logic [3:0] g);
    sdi = g; tick(); tick(); sck = 1'b1; tick(); tick(); sck = 1'b0;
  endtask

  task automatic send_bits(input logic [31:0] v, input int nbits);
    int k = kw();
    logic [3:0] msk = 4'((1 << k) - 1);
    for (int i = 0; i < nbits/k; i++) begin
      if (m_lsb) pulse(4'(v >> (i*k)) & msk);
      else       pulse(4'(v >> (nbits - (i+1)*k)) & msk);
    end
  endtask

  task automatic recv_bits(input int nbits, output logic [31:0] v);
    int k = kw();
    logic [3:0] msk = 4'((1 << k) - 1);
    logic [3:0] g;
    v = '0;
    for (int i = 0; i < nbits/k; i++) begin
      tick();
      g = (m_mode == 2'b01) ? {3'b0, rdat[2]} : (rdat & msk);
      if (m_lsb) v = v | (32'(g) << (i*k));
      else       v = (v << k) | 32'(g);
      pulse(4'h0);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] v);
    csb = 1'b0; tick();
    send_bits({24'h0, 3'b000, a}, 8);
    send_bits(v, 8*nbytes(a));
    tick(); csb = 1'b1; tick(); tick();
    if (a == 5'h00) begin
      m_lsb = v[0]; m_mode = v[2:1]; m_err = v[3]; m_spare = v[5:4]; m_en = v[7:6];
    end else if (a == 5'h01) m_fs = v[23:0];
    else if (a == 5'h04) begin
      if (m_en[0]) m_c0s = v;
      if (m_en[1]) m_c1s = v;
    end
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] v);
    csb = 1'b0; tick();
    send_bits({24'h0, 3'b100, a}, 8);
    recv_bits(8*nbytes(a), v);
    tick(); csb = 1'b1; tick(); tick();
  endtask

  task automatic do_update();
    io_update = 1'b1; tick();
    m_fa = m_fs; m_c0a = m_c0s; m_c1a = m_c1s;
    io_update = 1'b0; tick();
  endtask

  task automatic abort_write(input logic [4:0] a, input int groups);
    csb = 1'b0; tick();
    send_bits({24'h0, 3'b000, a}, 8);
    for (int i = 0; i < groups; i++) pulse(4'($urandom));
    tick(); csb = 1'b1; tick(); tick();
  endtask

  task automatic rd_check(input string req, input logic [4:0] a);
    logic [31:0] v;
    rd_reg(a, v);
    check(req, v, exp_read(a));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED));
    repeat (3) tick();
    rst_n = 1'b1; tick();
    // R1 reset state
    check_ports("R1 reset");
    rd_check("R1 R2 sel readback", 5'h00);
    // R7 staging, R11 edge-only update
    wr_reg(5'h01, 32'h00A5B6C7);
    check_ports("R7 staged not active");
    io_update = 1'b1; tick();
    m_fa = m_fs; m_c0a = m_c0s; m_c1a = m_c1s;
    check_ports("R7 copy on edge");
    wr_reg(5'h01, 32'h00123456);
    check_ports("R11 level held no copy");
    io_update = 1'b0; tick();
    do_update();
    check_ports("R11 next edge copies");
    // R8 steering, R6 immediate select
    wr_reg(5'h00, 32'h40);
    check_ports("R6 enables immediate");
    wr_reg(5'h04, 32'h11223344); do_update();
    check_ports("R8 en01 ch0 only");
    wr_reg(5'h00, 32'h80);
    wr_reg(5'h04, 32'h55667788); do_update();
    check_ports("R8 en10 ch1 only");
    rd_check("R9 en10 reads ch1", 5'h04);
    wr_reg(5'h00, 32'h00);
    rd_check("R9 en00 reads zero", 5'h04);
    wr_reg(5'h00, 32'hC0);
    rd_check("R9 en11 reads ch0", 5'h04);
    wr_reg(5'h04, 32'hCAFEF00D); do_update();
    check_ports("R8 en11 both");
    // R5 bit 3
    wr_reg(5'h00, 32'hC8);
    check_ports("R5 err set");
    rd_check("R5 bit3 reads 0", 5'h00);
    wr_reg(5'h00, 32'hC0);
    check_ports("R5 err cleared");
    // R10 abort
    abort_write(5'h01, 12);
    do_update();
    check_ports("R10 abort no change");
    rd_check("R10 next transfer ok", 5'h01);
    // R2 unused address
    wr_reg(5'h09, 32'h5A); do_update();
    check_ports("R2 unused write ignored");
    rd_check("R2 unused reads zero", 5'h09);
    // R3 R4 every order and lane mode
    for (int m = 0; m < 8; m++) begin
      wr_reg(5'h00, {24'h0, 2'b11, 3'b000, 3'(m)});
      check_ports("R4 R6 mode applied");
      wr_reg(5'h01, $urandom); wr_reg(5'h04, $urandom); do_update();
      check_ports("R3 R4 write in mode");
      rd_check("R3 R4 fr1 read in mode", 5'h01);
      rd_check("R3 R4 ch read in mode", 5'h04);
    end
    // random mix
    for (int it = 0; it < 120; it++) begin
      int op = $urandom_range(0, 6);
      case (op)
        0: begin
          v = $urandom;
          if ($urandom_range(0, 3) != 0) v[3] = 1'b0;
          wr_reg(5'h00, {24'h0, v[7:0]});
        end
        1: wr_reg(5'h01, $urandom);
        2: wr_reg(5'h04, $urandom);
        3: do_update();
        4: abort_write(($urandom_range(0, 1) != 0) ? 5'h04 : 5'h01, $urandom_range(0, 3));
        default: begin
          int s = $urandom_range(0, 3);
          rd_check("R2 R9 random read", (s == 0) ? 5'h00 : (s == 1) ? 5'h01 : (s == 2) ? 5'h04 : 5'h0B);
        end
      endcase
      check_ports("R7 R8 R10 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule